// File: doc/BRIEF.md
# Keyboard Scan-Code Wake Detector

This block listens, without ever driving them, to the clock and data lines of a PS/2-style keyboard and raises a power-management wake event when one chosen key code arrives. Both lines are brought into the system clock domain. A microsecond-tick timer measures how long the keyboard clock has stayed high. A receiver locks onto a frame only after a long enough quiet gap. It then shifts in the eleven bits of the frame on successive falling clock edges.

A frame counts as a hit only when all of the following hold: the start bit is 0, the eight data bits equal the programmed code, the eight data bits plus the parity bit hold an odd number of ones, and the stop bit is 1. A hit sets a sticky status flag. Software clears that flag by writing a one to it. The event pin is asserted while the flag and its enable are both set, and a polarity bit chooses the pin's active level.

Top module: `kbd_wake_det`

## Requirements
- R1: After reset the status flag is 0, the scan code is 0x00, enable and polarity are 0, and `pme_out` rests at its idle level, which is 1.
- R2: A frame that follows a clock-high gap of at least GAP_MIN_US microseconds and meets all four conditions sets the status flag. The conditions are: start bit 0, data bits (least significant bit first) equal to the code, odd parity over data plus parity, and stop bit 1.
- R3: A falling edge that comes after a clock-high time shorter than GAP_MIN_US does not start a frame.
- R4: A frame with even parity over its data and parity bits leaves the status flag unchanged.
- R5: A frame whose stop bit is 0 leaves the status flag unchanged.
- R6: A frame whose data differs from the code leaves the status flag unchanged, whether the flag is 0 or 1.
- R7: The status flag stays set until a write to address 2 with bit 0 = 1 clears it. A write to address 2 with bit 0 = 0 has no effect on the flag.
- R8: `pme_out` equals the polarity bit while status and enable are both 1, and equals its inverse otherwise. Polarity 1 means active high.
- R9: If the keyboard clock stays high for GAP_MAX_US microseconds or more inside a frame, the partial frame is dropped and the next falling edge after the gap is treated as a new start bit.
- R10: Register map: address 0 holds the scan code (8 bits, read/write). Address 1 holds enable in bit 0 and polarity in bit 1 (read/write). Address 2 holds the status flag in bit 0 (read, write-one-to-clear). Address 3 reads 0.
- R11: If the data line is 1 on the first falling edge after a gap, no frame starts. The edges that follow, before a new gap, start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kb_clk | input | 1 | Keyboard clock line, asynchronous |
| kb_dat | input | 1 | Keyboard data line, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the address |
| pme_out | output | 1 | Wake event pin, level chosen by polarity |

## Verification
A falling edge of the keyboard clock passes two synchronizer flops before the edge detector sees it. The receiver registers its hit one cycle later, and the status flag follows one cycle after that. The status therefore changes on the fourth system clock edge after the stop-bit edge. The bench reads the status only after the stop-bit low phase and the following high phase, which is tens of microseconds later, so it never samples inside that window. Register writes take effect on the next clock edge, and the bench reads them half a cycle later. The gap tests use 100 us and 130 us, which stay well clear of the 115 us threshold given the one-tick uncertainty of the timer.

// File: rtl/kw_pkg.sv
`timescale 1ns/1ps
package kw_pkg;
  localparam int FRAME_BITS = 11;
  localparam int STOP_IDX   = FRAME_BITS - 1;

  // odd parity holds when data plus parity carry an odd count of ones
  function automatic logic parity_odd(input logic [7:0] d, input logic p);
    return ^{d, p};
  endfunction

  function automatic logic frame_hit(input logic [9:0] f, input logic [7:0] code);
    return f[9] && parity_odd(f[7:0], f[8]) && (f[7:0] == code);
  endfunction
endpackage

// File: rtl/kw_sync.sv
`timescale 1ns/1ps
module kw_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
      end else begin
        s1 <= d_in[g];
        s2 <= s1;
      end
    end
    assign d_out[g] = s2;
  end
endmodule

// File: rtl/kw_gap_timer.sv
`timescale 1ns/1ps
module kw_gap_timer #(
  parameter int CLK_PER_US = 4,
  parameter int GAP_MIN_US = 115,
  parameter int GAP_MAX_US = 145
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_hi,
  output logic gap_ok,
  output logic idle_to
);
  localparam int PW = $clog2(CLK_PER_US + 1);
  localparam int HW = $clog2(GAP_MAX_US + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_US - 1);
  localparam logic [HW-1:0] HI_MIN   = HW'(GAP_MIN_US);
  localparam logic [HW-1:0] HI_MAX   = HW'(GAP_MAX_US);

  logic [PW-1:0] pre;
  logic [HW-1:0] hi_us;
  logic          us_tick;

  assign us_tick = (pre == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre <= '0;
    else if (us_tick) pre <= '0;
    else pre <= pre + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_us <= '0;
    else if (!line_hi) hi_us <= '0;
    else if (us_tick && hi_us < HI_MAX) hi_us <= hi_us + 1'b1;
  end

  assign gap_ok  = (hi_us >= HI_MIN);
  assign idle_to = (hi_us >= HI_MAX);
endmodule

// File: rtl/kw_frame_rx.sv
`timescale 1ns/1ps
module kw_frame_rx
  import kw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_fall,
  input  logic       s_dat,
  input  logic       gap_ok,
  input  logic       idle_to,
  input  logic [7:0] code,
  output logic       in_frame,
  output logic       hit
);
  logic [3:0] bit_cnt;
  logic [9:0] sh;
  logic [9:0] sh_nxt;

  assign sh_nxt = {s_dat, sh[9:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      bit_cnt  <= '0;
      sh       <= '0;
      hit      <= 1'b0;
    end else begin
      hit <= 1'b0;
      if (!in_frame) begin
        if (clk_fall && gap_ok && !s_dat) begin
          in_frame <= 1'b1;
          bit_cnt  <= 4'd1;
        end
      end else if (idle_to) begin
        in_frame <= 1'b0;
      end else if (clk_fall) begin
        sh      <= sh_nxt;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == 4'(STOP_IDX)) begin
          in_frame <= 1'b0;
          hit      <= frame_hit(sh_nxt, code);
        end
      end
    end
  end
endmodule

// File: rtl/kw_evt_reg.sv
`timescale 1ns/1ps
module kw_evt_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       hit,
  output logic [7:0] code,
  output logic       en,
  output logic       pol,
  output logic       sts,
  output logic       clr_req,
  output logic [7:0] reg_rdata,
  output logic       pme_out
);
  assign clr_req = reg_wr && (reg_addr == 2'd2) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
      en   <= 1'b0;
      pol  <= 1'b0;
      sts  <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == 2'd0) code <= reg_wdata;
      if (reg_wr && reg_addr == 2'd1) begin
        en  <= reg_wdata[0];
        pol <= reg_wdata[1];
      end
      if (hit) sts <= 1'b1;
      else if (clr_req) sts <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = code;
      2'd1:    reg_rdata = {6'd0, pol, en};
      2'd2:    reg_rdata = {7'd0, sts};
      default: reg_rdata = 8'd0;
    endcase
  end

  assign pme_out = (sts && en) ? pol : ~pol;
endmodule

// File: rtl/kbd_wake_det.sv
`timescale 1ns/1ps
module kbd_wake_det #(
  parameter int CLK_PER_US = 4,
  parameter int GAP_MIN_US = 115,
  parameter int GAP_MAX_US = 145
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kb_clk,
  input  logic       kb_dat,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       pme_out
);
  logic [1:0] s_lines;
  logic       s_clk, s_dat, s_clk_q;
  logic       clk_fall, gap_ok, idle_to, in_frame, hit;
  logic [7:0] code;
  logic       en, pol, sts, clr_req;

  kw_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in({kb_dat, kb_clk}), .d_out(s_lines)
  );
  assign s_clk = s_lines[0];
  assign s_dat = s_lines[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_clk_q <= 1'b1;
    else s_clk_q <= s_clk;
  end
  assign clk_fall = s_clk_q && !s_clk;

  kw_gap_timer #(
    .CLK_PER_US(CLK_PER_US), .GAP_MIN_US(GAP_MIN_US), .GAP_MAX_US(GAP_MAX_US)
  ) u_gap (
    .clk(clk), .rst_n(rst_n), .line_hi(s_clk), .gap_ok(gap_ok), .idle_to(idle_to)
  );

  kw_frame_rx u_rx (
    .clk(clk), .rst_n(rst_n), .clk_fall(clk_fall), .s_dat(s_dat),
    .gap_ok(gap_ok), .idle_to(idle_to), .code(code),
    .in_frame(in_frame), .hit(hit)
  );

  kw_evt_reg u_reg (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .hit(hit), .code(code), .en(en), .pol(pol),
    .sts(sts), .clr_req(clr_req), .reg_rdata(reg_rdata), .pme_out(pme_out)
  );
endmodule

// File: rtl/kw_checker.sv
`timescale 1ns/1ps
module kw_checker (
  input logic clk,
  input logic rst_n,
  input logic clk_fall,
  input logic gap_ok,
  input logic idle_to,
  input logic in_frame,
  input logic hit,
  input logic sts,
  input logic clr_req
);
  AST_START_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |-> $past(gap_ok && clk_fall)); // R3
  AST_HIT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(clk_fall)); // R2
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !sts) |=> !sts); // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts && !clr_req) |=> sts); // R7
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !hit) |=> !sts); // R7
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && idle_to) |=> !in_frame); // R9
endmodule

bind kbd_wake_det kw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .clk_fall(clk_fall), .gap_ok(gap_ok),
  .idle_to(idle_to), .in_frame(in_frame), .hit(hit), .sts(sts), .clr_req(clr_req)
);

// File: tb/kbd_wake_det_tb.sv
`timescale 1ns/1ps
module kbd_wake_det_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 4;
  localparam int US         = CLK_PERIOD * CPU;

  logic clk = 1'b0, rst_n = 1'b0;
  logic kb_clk = 1'b1, kb_dat = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic pme_out;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  kbd_wake_det #(.CLK_PER_US(CPU), .GAP_MIN_US(115), .GAP_MAX_US(145)) u_dut (
    .clk(clk), .rst_n(rst_n), .kb_clk(kb_clk), .kb_dat(kb_dat),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pme_out(pme_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic odd_par_bit(input logic [7:0] b);
    int n = 0;
    for (int i = 0; i < 8; i++) if (b[i]) n++;
    return (n % 2 == 0);
  endfunction

  // stray edge with data high, then high gap, then nbits of the frame
  task automatic send(input logic [7:0] b, input bit bad_par, input bit stop_b,
                      input bit start_b, input int gap_us, input int nbits);
    logic [10:0] f;
    f = {stop_b, odd_par_bit(b) ^ bad_par, b, start_b};
    kb_dat = 1'b1; kb_clk = 1'b0; #(5*US); kb_clk = 1'b1;
    #(gap_us*US);
    for (int i = 0; i < nbits; i++) begin
      kb_dat = f[i];
      kb_clk = 1'b0; #(20*US);
      kb_clk = 1'b1; #(10*US);
      if (i + 1 < nbits) #(10*US);
    end
    kb_dat = 1'b1;
    #(10*US);
  endtask

  task automatic expect_sts(input string req, input int exp);
    logic [7:0] d;
    rd(2'd2, d);
    check(req, d[0], exp);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 pme idle", pme_out, 1);
    rd(2'd0, d); check("R1 code", d, 0);
    rd(2'd1, d); check("R1 ctrl", d, 0);
    expect_sts("R1 status", 0);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(2'd0, 8'h1C); rd(2'd0, d); check("R10 code", d, 8'h1C);
    wr(2'd1, 8'h01); rd(2'd1, d); check("R10 ctrl", d, 8'h01);
    rd(2'd3, d); check("R10 addr3", d, 0);
  endtask

  task automatic t_match;
    send(8'h1C, 0, 1, 0, 130, 11);
    expect_sts("R2 match sets", 1);
    check("R8 active low", pme_out, 0);
  endtask

  task automatic t_clear;
    wr(2'd2, 8'h00); expect_sts("R7 write0 keeps", 1);
    wr(2'd2, 8'h01); expect_sts("R7 write1 clears", 0);
    check("R8 idle after clear", pme_out, 1);
  endtask

  task automatic t_rejects;
    send(8'h1C, 0, 1, 0, 100, 11); expect_sts("R3 short gap", 0);
    send(8'h1C, 1, 1, 0, 130, 11); expect_sts("R4 bad parity", 0);
    send(8'h1C, 0, 0, 0, 130, 11); expect_sts("R5 stop zero", 0);
    send(8'h1C, 0, 1, 1, 130, 11); expect_sts("R11 start one", 0);
    send(8'h1D, 0, 1, 0, 130, 11); expect_sts("R6 mismatch clear", 0);
  endtask

  task automatic t_sticky_mismatch;
    send(8'h1C, 0, 1, 0, 130, 11); expect_sts("R2 second match", 1);
    send(8'h3A, 0, 1, 0, 130, 11); expect_sts("R6 mismatch keeps set", 1);
    wr(2'd2, 8'h01); expect_sts("R7 clear again", 0);
  endtask

  task automatic t_abort;
    wr(2'd1, 8'h03);
    check("R8 high-active idle", pme_out, 0);
    send(8'h1C, 0, 1, 0, 130, 6);
    #(160*US);
    send(8'h1C, 0, 1, 0, 130, 11);
    expect_sts("R9 resync after abort", 1);
    check("R8 active high", pme_out, 1);
    wr(2'd1, 8'h02);
    check("R8 disabled", pme_out, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_regs();
    t_match();
    t_clear();
    t_rejects();
    t_sticky_mismatch();
    t_abort();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule